// File: doc/BRIEF.md
# Data-Space Access Router with Core I/O Registers

This block sits between the load/store unit of a small microcontroller core and the storage that the core's single-byte data accesses reach. A request carries either a flat data-space address or, for the dedicated port instructions, a bare I/O port number. The router decides where the byte lives. The lowest addresses select the general register file, which the block drives through a narrow read/write port. The next window selects I/O ports. Anything above that window goes out to external data memory.

The top eight ports of the I/O window are the core's own registers. Four page registers extend the X, Y, Z and plain data pointers. A further register extends indirect jumps. The stack pointer is split into low and high bytes. The status byte lives in the core and is reached through a separate status interface. The router keeps the page, jump-extension and stack-pointer registers locally and presents them as outputs. Every other I/O port, and all of data memory, is reached over a memory-mapped bus with a valid/ready handshake.

Local accesses finish in one cycle and give registered read data. Bus accesses hold the request until the bus accepts it, and only one access is in flight at a time. Feature parameters select which page registers exist and whether the stack pointer has a high byte.

Top module: `dspace_router`

## Requirements
- R1: In data mode, an address below REG_COUNT (default 32) targets the register file. `rfAddr` carries the address, `rfWe` pulses in the accept cycle of a write, and a read returns `rfRdata` as captured at acceptance.
- R2: In data mode, an address from REG_COUNT up to REG_COUNT+IO_COUNT-1 targets I/O port (address − REG_COUNT). A port below IO_COUNT−8 is forwarded to the bus at IO_BASE (default 0x20) plus the port number.
- R3: In data mode, an address at or above REG_COUNT+IO_COUNT (default 96) is forwarded to the bus at MEM_BASE (default 0) plus the address.
- R4: With `reqPort` high, the low log2(IO_COUNT) bits of `reqAddr` give the I/O port number directly, and that port is handled exactly as in R2 and R5.
- R5: Core ports sit at IO_COUNT−8 and up: +0 data page, +1 X page, +2 Y page, +3 Z page, +4 jump extension, +5 stack-pointer low, +6 stack-pointer high, +7 status. Status reads and writes use `sregRdata`/`sregWe`/`sregWdata`. No core port ever reaches the bus.
- R6: A page or jump-extension register holds its written byte in bits 23:16 of its 24-bit output, with all other bits zero. Reading it returns that byte.
- R7: A write to a page register takes effect only if its bit in PAGE_EN is set (bit 0 data, 1 X, 2 Y, 3 Z). Otherwise the write is ignored and the register reads zero. Writes to the jump-extension register always take effect.
- R8: A stack-pointer low write replaces `spOut[7:0]` only. A high write replaces `spOut[15:8]` only when SP_TWO_BYTE is 1, and is ignored otherwise. The low read returns bits 7:0 and the high read returns the pointer shifted right by 8.
- R9: A local access (register file or core port) is accepted while `reqReady` is high. `rspValid` is high for exactly the one cycle after acceptance. A write returns `rspRdata` 0.
- R10: A bus access holds `busValid`, `busAddr`, `busWrite` and `busWdata` steady until `busReady`, and keeps `reqReady` low meanwhile. `rspValid` follows one cycle after the handshake, carrying `busRdata` for a read or 0 for a write.
- R11: After reset, `reqReady` is 1, `rspValid` and `busValid` are 0, and the stack pointer, page and jump-extension outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Router can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqPort | input | 1 | 1 = address is an I/O port number |
| reqAddr | input | ADDR_W | Data-space address or port number |
| reqWdata | input | 8 | Store byte |
| rspValid | output | 1 | Access complete, one cycle |
| rspRdata | output | 8 | Registered load result |
| rfAddr | output | log2(REG_COUNT) | Register-file index |
| rfWe | output | 1 | Register-file write strobe |
| rfWdata | output | 8 | Register-file write byte |
| rfRdata | input | 8 | Register-file read byte |
| sregWe | output | 1 | Status write strobe |
| sregWdata | output | 8 | Status write byte |
| sregRdata | input | 8 | Current status byte |
| busValid | output | 1 | Bus request valid |
| busReady | input | 1 | Bus accepts/completes request |
| busWrite | output | 1 | Bus request is a write |
| busAddr | output | BUS_AW | Bus byte address |
| busWdata | output | 8 | Bus write byte |
| busRdata | input | 8 | Bus read byte |
| spOut | output | 16 | Stack pointer |
| pageDOut | output | 24 | Data page register |
| pageXOut | output | 24 | X page register |
| pageYOut | output | 24 | Y page register |
| pageZOut | output | 24 | Z page register |
| eindOut | output | 24 | Jump-extension register |

## Verification
The bench probes the window edges: the last register-file address, the first and last forwarded I/O ports, and the first memory address. An off-by-one in the decode would send one of these to the wrong target or to a wrong bus address. It writes every core port and confirms that no bus transfer occurs. It also writes a disabled page register and, on a second instance built with a one-byte stack pointer, the stack-pointer high byte. A design that ignored the feature options would show a changed output or read-back. Writing the low stack byte after the high one catches a design that clears or overwrites the other half. During a slow bus reply the bench watches for an early response, a second acceptance, or a bus address that moves before the handshake.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    TGT_RF     = 2'd0,
    TGT_CORE   = 2'd1,
    TGT_IO_BUS = 2'd2,
    TGT_MEMBUS = 2'd3
  } tgt_e;

  // core register index = port - (IO_COUNT - 8)
  localparam logic [2:0] CR_PAGE_D = 3'd0;
  localparam logic [2:0] CR_PAGE_X = 3'd1;
  localparam logic [2:0] CR_PAGE_Y = 3'd2;
  localparam logic [2:0] CR_PAGE_Z = 3'd3;
  localparam logic [2:0] CR_EIND   = 3'd4;
  localparam logic [2:0] CR_SP_LO  = 3'd5;
  localparam logic [2:0] CR_SP_HI  = 3'd6;
  localparam logic [2:0] CR_STATUS = 3'd7;

  typedef struct packed {
    logic       accept;    // request taken this cycle
    logic       write;
    tgt_e       tgt;
    logic [2:0] coreIdx;
    logic       busLaunch; // capture bus request this cycle
    logic       busDone;   // bus handshake this cycle
  } strobe_t;

endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int IO_COUNT  = 64,
  parameter int ADDR_W    = 16,
  localparam int IO_AW    = $clog2(IO_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              busReady,
  output logic              reqReady,
  output logic              busValid,
  output logic              rspValid,
  output logic [IO_AW-1:0]  ioPort,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] RF_END     = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] IO_END     = ADDR_W'(REG_COUNT + IO_COUNT);
  localparam logic [IO_AW-1:0]  CORE_FIRST = IO_AW'(IO_COUNT - 8);

  logic busy;
  logic inIo;
  tgt_e tgt;
  logic isBus;

  // address decode
  always_comb begin
    inIo   = 1'b0;
    ioPort = '0;
    tgt    = TGT_MEMBUS;
    if (reqPort) begin
      inIo   = 1'b1;
      ioPort = reqAddr[IO_AW-1:0];
    end else if (reqAddr < RF_END) begin
      tgt = TGT_RF;
    end else if (reqAddr < IO_END) begin
      inIo   = 1'b1;
      ioPort = IO_AW'(reqAddr - RF_END);
    end
    if (inIo) begin
      tgt = (ioPort >= CORE_FIRST) ? TGT_CORE : TGT_IO_BUS;
    end
  end

  assign isBus    = (tgt == TGT_IO_BUS) || (tgt == TGT_MEMBUS);
  assign reqReady = !busy;
  assign busValid = busy;

  always_comb begin
    strb           = '0;
    strb.accept    = reqValid && !busy;
    strb.write     = reqWrite;
    strb.tgt       = tgt;
    strb.coreIdx   = ioPort[2:0];
    strb.busLaunch = reqValid && !busy && isBus;
    strb.busDone   = busy && busReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= (strb.accept && !isBus) || strb.busDone;
      if (strb.busLaunch)     busy <= 1'b1;
      else if (strb.busDone)  busy <= 1'b0;
    end
  end

  // R10: request held until the bus answers
  a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid);
  // R10: no second acceptance while a bus transfer is open
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);
  // R10: response follows the handshake and frees the router
  a_r10_bus_rsp: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busReady |=> rspValid && reqReady);
  // R9: local access answers in the next cycle
  a_r9_local_rsp: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !isBus |=> rspValid && !busValid);

endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath
  import dsr_pkg::*;
#(
  parameter int          REG_COUNT   = 32,
  parameter int          IO_COUNT    = 64,
  parameter int          ADDR_W      = 16,
  parameter int          BUS_AW      = 16,
  parameter int          IO_BASE     = 32,
  parameter int          MEM_BASE    = 0,
  parameter logic [3:0]  PAGE_EN     = 4'b1111,
  parameter bit          SP_TWO_BYTE = 1'b1,
  localparam int         IO_AW       = $clog2(IO_COUNT),
  localparam int         RF_AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IO_AW-1:0]  ioPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  input  logic [7:0]        rfRdata,
  input  logic [7:0]        sregRdata,
  input  logic [7:0]        busRdata,
  output logic [RF_AW-1:0]  rfAddr,
  output logic              rfWe,
  output logic [7:0]        rfWdata,
  output logic              sregWe,
  output logic [7:0]        sregWdata,
  output logic [BUS_AW-1:0] busAddr,
  output logic              busWrite,
  output logic [7:0]        busWdata,
  output logic [7:0]        rspRdata,
  output logic [15:0]       spOut,
  output logic [23:0]       pageDOut,
  output logic [23:0]       pageXOut,
  output logic [23:0]       pageYOut,
  output logic [23:0]       pageZOut,
  output logic [23:0]       eindOut
);

  localparam logic [BUS_AW-1:0] IO_BASE_A  = BUS_AW'(IO_BASE);
  localparam logic [BUS_AW-1:0] MEM_BASE_A = BUS_AW'(MEM_BASE);

  logic       coreWr;
  logic [7:0] pageByte [4];
  logic [7:0] eindByte;
  logic [7:0] spLo;
  logic [7:0] spHi;
  logic [7:0] coreRd;
  logic [7:0] localRd;

  assign coreWr = strb.accept && strb.write && (strb.tgt == TGT_CORE);

  // register file and status side ports
  assign rfAddr    = reqAddr[RF_AW-1:0];
  assign rfWe      = strb.accept && strb.write && (strb.tgt == TGT_RF);
  assign rfWdata   = reqWdata;
  assign sregWe    = coreWr && (strb.coreIdx == CR_STATUS);
  assign sregWdata = reqWdata;

  // page registers, each present only when its feature bit is set
  for (genvar i = 0; i < 4; i++) begin : g_page
    if (PAGE_EN[i]) begin : g_on
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                        q <= '0;
        else if (coreWr && strb.coreIdx == 3'(i))         q <= reqWdata;
      end
      assign pageByte[i] = q;
      // R7: enabled page register takes the written byte
      a_r7_page_write: assert property (@(posedge clk) disable iff (!rstN)
        coreWr && strb.coreIdx == 3'(i) |=> q == $past(reqWdata));
    end else begin : g_off
      assign pageByte[i] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      eindByte <= '0;
    else if (coreWr && strb.coreIdx == CR_EIND)     eindByte <= reqWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      spLo <= '0;
    else if (coreWr && strb.coreIdx == CR_SP_LO)    spLo <= reqWdata;
  end

  if (SP_TWO_BYTE) begin : g_sphi
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    q <= '0;
      else if (coreWr && strb.coreIdx == CR_SP_HI)  q <= reqWdata;
    end
    assign spHi = q;
    // R8: high byte written only by its own port
    a_r8_sp_hi_write: assert property (@(posedge clk) disable iff (!rstN)
      coreWr && strb.coreIdx == CR_SP_HI |=> q == $past(reqWdata) && spLo == $past(spLo));
  end else begin : g_sphi_none
    assign spHi = 8'h00;
  end

  assign spOut    = {spHi, spLo};
  assign pageDOut = {pageByte[0], 16'h0000};
  assign pageXOut = {pageByte[1], 16'h0000};
  assign pageYOut = {pageByte[2], 16'h0000};
  assign pageZOut = {pageByte[3], 16'h0000};
  assign eindOut  = {eindByte, 16'h0000};

  // core register read mux
  always_comb begin
    case (strb.coreIdx)
      CR_EIND:   coreRd = eindByte;
      CR_SP_LO:  coreRd = spLo;
      CR_SP_HI:  coreRd = spHi;
      CR_STATUS: coreRd = sregRdata;
      default:   coreRd = pageByte[strb.coreIdx[1:0]];
    endcase
  end

  assign localRd = (strb.tgt == TGT_RF) ? rfRdata : coreRd;

  // bus request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busWrite <= 1'b0;
      busWdata <= '0;
    end else if (strb.busLaunch) begin
      busAddr  <= (strb.tgt == TGT_IO_BUS) ? IO_BASE_A + BUS_AW'(ioPort)
                                           : MEM_BASE_A + BUS_AW'(reqAddr);
      busWrite <= strb.write;
      busWdata <= strb.write ? reqWdata : 8'h00;
    end
  end

  // registered response data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (strb.accept && (strb.tgt == TGT_RF || strb.tgt == TGT_CORE)) begin
      rspRdata <= strb.write ? 8'h00 : localRd;
    end else if (strb.busDone) begin
      rspRdata <= busWrite ? 8'h00 : busRdata;
    end
  end

  // R8: low write leaves the high byte alone
  a_r8_sp_lo_write: assert property (@(posedge clk) disable iff (!rstN)
    coreWr && strb.coreIdx == CR_SP_LO |=> spLo == $past(reqWdata) && spHi == $past(spHi));
  // R7: jump extension always written
  a_r7_eind_write: assert property (@(posedge clk) disable iff (!rstN)
    coreWr && strb.coreIdx == CR_EIND |=> eindByte == $past(reqWdata));
  // R5: at most one destination strobed per cycle
  a_r5_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rfWe, sregWe, strb.busLaunch}));
  // R10: bus request fields steady while waiting
  a_r10_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    strb.busLaunch |=> !strb.busLaunch);

endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dsr_pkg::*;
#(
  parameter int          REG_COUNT   = 32,
  parameter int          IO_COUNT    = 64,
  parameter int          ADDR_W      = 16,
  parameter int          BUS_AW      = 16,
  parameter int          IO_BASE     = 32,
  parameter int          MEM_BASE    = 0,
  parameter logic [3:0]  PAGE_EN     = 4'b1111,
  parameter bit          SP_TWO_BYTE = 1'b1,
  localparam int         IO_AW       = $clog2(IO_COUNT),
  localparam int         RF_AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic [7:0]        rspRdata,
  output logic [RF_AW-1:0]  rfAddr,
  output logic              rfWe,
  output logic [7:0]        rfWdata,
  input  logic [7:0]        rfRdata,
  output logic              sregWe,
  output logic [7:0]        sregWdata,
  input  logic [7:0]        sregRdata,
  output logic              busValid,
  input  logic              busReady,
  output logic              busWrite,
  output logic [BUS_AW-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata,
  output logic [15:0]       spOut,
  output logic [23:0]       pageDOut,
  output logic [23:0]       pageXOut,
  output logic [23:0]       pageYOut,
  output logic [23:0]       pageZOut,
  output logic [23:0]       eindOut
);

  strobe_t          strb;
  logic [IO_AW-1:0] ioPort;

  dsr_ctrl #(
    .REG_COUNT(REG_COUNT), .IO_COUNT(IO_COUNT), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPort(reqPort), .reqAddr(reqAddr), .busReady(busReady),
    .reqReady(reqReady), .busValid(busValid), .rspValid(rspValid),
    .ioPort(ioPort), .strb(strb)
  );

  dsr_datapath #(
    .REG_COUNT(REG_COUNT), .IO_COUNT(IO_COUNT), .ADDR_W(ADDR_W),
    .BUS_AW(BUS_AW), .IO_BASE(IO_BASE), .MEM_BASE(MEM_BASE),
    .PAGE_EN(PAGE_EN), .SP_TWO_BYTE(SP_TWO_BYTE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioPort(ioPort), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rfRdata(rfRdata), .sregRdata(sregRdata),
    .busRdata(busRdata), .rfAddr(rfAddr), .rfWe(rfWe), .rfWdata(rfWdata),
    .sregWe(sregWe), .sregWdata(sregWdata), .busAddr(busAddr),
    .busWrite(busWrite), .busWdata(busWdata), .rspRdata(rspRdata),
    .spOut(spOut), .pageDOut(pageDOut), .pageXOut(pageXOut),
    .pageYOut(pageYOut), .pageZOut(pageZOut), .eindOut(eindOut)
  );

  // R11: reset state visible at the request side
  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> reqReady);

endmodule

// File: tb/sim_dspace_router.sv
`timescale 1ns/1ps
module sim_dspace_router;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // ---------------- u0: Y page disabled, two-byte stack pointer
  logic        reqValid = 0, reqWrite = 0, reqPort = 0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid, rfWe, sregWe, busValid, busWrite;
  logic        busReady = 0;
  logic [7:0]  rspRdata, rfWdata, rfRdata, sregWdata, sregRdata, busWdata, busRdata;
  logic [4:0]  rfAddr;
  logic [15:0] busAddr, spOut;
  logic [23:0] pageDOut, pageXOut, pageYOut, pageZOut, eindOut;

  dspace_router #(.PAGE_EN(4'b1011), .SP_TWO_BYTE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqPort(reqPort), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rfAddr(rfAddr), .rfWe(rfWe),
    .rfWdata(rfWdata), .rfRdata(rfRdata), .sregWe(sregWe), .sregWdata(sregWdata),
    .sregRdata(sregRdata), .busValid(busValid), .busReady(busReady),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .spOut(spOut), .pageDOut(pageDOut), .pageXOut(pageXOut), .pageYOut(pageYOut),
    .pageZOut(pageZOut), .eindOut(eindOut)
  );

  // ---------------- u1: one-byte stack pointer
  logic        v1 = 0, w1 = 0;
  logic [15:0] a1 = '0;
  logic [7:0]  d1 = '0;
  logic        rdy1, rv1, rfWe1, sWe1, bv1, bw1;
  logic [7:0]  rd1, rfWd1, sWd1, bWd1;
  logic [4:0]  rfA1;
  logic [15:0] bA1, sp1;
  logic [23:0] pD1, pX1, pY1, pZ1, e1;

  dspace_router #(.SP_TWO_BYTE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(v1), .reqReady(rdy1), .reqWrite(w1),
    .reqPort(1'b1), .reqAddr(a1), .reqWdata(d1), .rspValid(rv1), .rspRdata(rd1),
    .rfAddr(rfA1), .rfWe(rfWe1), .rfWdata(rfWd1), .rfRdata(8'h00),
    .sregWe(sWe1), .sregWdata(sWd1), .sregRdata(8'h00), .busValid(bv1),
    .busReady(1'b1), .busWrite(bw1), .busAddr(bA1), .busWdata(bWd1),
    .busRdata(8'h00), .spOut(sp1), .pageDOut(pD1), .pageXOut(pX1),
    .pageYOut(pY1), .pageZOut(pZ1), .eindOut(e1)
  );

  // ---------------- environment models
  assign rfRdata  = {3'b000, rfAddr} ^ 8'h3C;
  assign busRdata = busAddr[7:0] ^ 8'h5A;
  logic [7:0] sregVal = 8'h00;
  assign sregRdata = sregVal;

  int         busLat = 0;
  int         busXfers = 0, rfWrites = 0, protoBad = 0;
  logic [15:0] lastBusAddr = '0, prevBusAddr = '0;
  logic        lastBusWr = 0, prevBusValid = 0;
  logic [7:0]  lastBusWd = '0, lastRfWd = '0;
  logic [4:0]  lastRfAddr = '0;

  always @(posedge clk) begin
    if (busReady) begin
      busReady <= 1'b0;
      busLat   <= 0;
    end else if (busValid) begin
      if (busLat == 2) busReady <= 1'b1;
      else             busLat   <= busLat + 1;
    end
    if (busValid && busReady) begin
      lastBusAddr <= busAddr;
      lastBusWr   <= busWrite;
      lastBusWd   <= busWdata;
      busXfers    <= busXfers + 1;
    end
    if (busValid && prevBusValid && busAddr != prevBusAddr) protoBad <= protoBad + 1;
    prevBusValid <= busValid && !busReady;
    prevBusAddr  <= busAddr;
    if (rfWe) begin
      lastRfAddr <= rfAddr;
      lastRfWd   <= rfWdata;
      rfWrites   <= rfWrites + 1;
    end
    if (sregWe) sregVal <= sregWdata;
  end

  always @(negedge clk) begin
    if (rstN && busValid && (reqReady || rspValid)) protoBad <= protoBad + 1;
  end

  // ---------------- helpers
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit pm, input logic [15:0] a,
                     input logic [7:0] wd, output logic [7:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqPort = pm; reqAddr = a; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!rspValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rspRdata;
  endtask

  task automatic acc1(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                      output logic [7:0] rd);
    @(negedge clk);
    v1 = 1'b1; w1 = wr; a1 = a; d1 = wd;
    @(posedge clk);
    @(negedge clk);
    v1 = 1'b0;
    rd = rd1;
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    chk("R11 reqReady", reqReady, 1);
    chk("R11 rspValid", rspValid, 0);
    chk("R11 busValid", busValid, 0);
    chk("R11 sp", spOut, 0);
    chk("R11 pages", {pageDOut, pageXOut, pageZOut, eindOut} == '0, 1);
  endtask

  task automatic t_regfile();
    logic [7:0] rd; int lat; int w0;
    w0 = rfWrites;
    acc(1, 0, 16'd5, 8'hA7, rd, lat);
    chk("R1 rf write addr", lastRfAddr, 5);
    chk("R1 rf write data", lastRfWd, 8'hA7);
    chk("R1 rf one strobe", rfWrites - w0, 1);
    chk("R9 write rsp data", rd, 0);
    chk("R9 local latency", lat, 0);
    @(negedge clk);
    chk("R9 rsp one cycle", rspValid, 0);
    acc(0, 0, 16'd31, 8'h00, rd, lat);
    chk("R1 rf read last", rd, 8'h1F ^ 8'h3C);
  endtask

  task automatic t_io_bus();
    logic [7:0] rd; int lat;
    acc(0, 0, 16'h0030, 8'h00, rd, lat);
    chk("R2 io read addr", lastBusAddr, 16'h0030);
    chk("R2 io read data", rd, 8'h30 ^ 8'h5A);
    chk("R10 bus latency", lat, 4);
    acc(1, 0, 16'h0057, 8'hC3, rd, lat);
    chk("R2 last fwd port addr", lastBusAddr, 16'h0057);
    chk("R2 io write data", {lastBusWr, lastBusWd}, {1'b1, 8'hC3});
    chk("R10 bus write rsp", rd, 0);
    acc(0, 0, 16'h0020, 8'h00, rd, lat);
    chk("R2 first port addr", lastBusAddr, 16'h0020);
  endtask

  task automatic t_mem_bus();
    logic [7:0] rd; int lat;
    acc(0, 0, 16'h0060, 8'h00, rd, lat);
    chk("R3 first mem addr", lastBusAddr, 16'h0060);
    chk("R3 first mem data", rd, 8'h60 ^ 8'h5A);
    acc(1, 0, 16'h1234, 8'h9E, rd, lat);
    chk("R3 high mem write", {lastBusAddr, lastBusWr, lastBusWd}, {16'h1234, 1'b1, 8'h9E});
    chk("R10 protocol", protoBad, 0);
  endtask

  task automatic t_port_mode();
    logic [7:0] rd; int lat;
    acc(1, 1, 16'h0005, 8'h11, rd, lat);
    chk("R4 port fwd addr", lastBusAddr, 16'h0025);
    acc(0, 1, 16'h0045, 8'h00, rd, lat);
    chk("R4 port low bits", lastBusAddr, 16'h0025);
  endtask

  task automatic t_core_regs();
    logic [7:0] rd; int lat; int x0;
    x0 = busXfers;
    acc(1, 0, 16'h0058, 8'h5C, rd, lat);
    chk("R6 page D out", pageDOut, 24'h5C0000);
    acc(1, 1, 16'h0039, 8'h81, rd, lat);
    chk("R6 page X out", pageXOut, 24'h810000);
    acc(1, 0, 16'h005A, 8'h77, rd, lat);
    chk("R7 disabled Y out", pageYOut, 0);
    acc(0, 0, 16'h005A, 8'h00, rd, lat);
    chk("R7 disabled Y read", rd, 0);
    acc(1, 0, 16'h005B, 8'hE4, rd, lat);
    chk("R6 page Z out", pageZOut, 24'hE40000);
    acc(1, 0, 16'h005C, 8'h3B, rd, lat);
    chk("R7 eind out", eindOut, 24'h3B0000);
    acc(0, 1, 16'h0038, 8'h00, rd, lat);
    chk("R6 page D read", rd, 8'h5C);
    acc(0, 0, 16'h005C, 8'h00, rd, lat);
    chk("R6 eind read", rd, 8'h3B);
    acc(1, 0, 16'h005F, 8'hA5, rd, lat);
    chk("R5 status write", sregVal, 8'hA5);
    acc(0, 1, 16'h003F, 8'h00, rd, lat);
    chk("R5 status read", rd, 8'hA5);
    chk("R5 core never on bus", busXfers - x0, 0);
  endtask

  task automatic t_stack();
    logic [7:0] rd; int lat;
    acc(1, 0, 16'h005D, 8'h34, rd, lat);
    chk("R8 sp low", spOut, 16'h0034);
    acc(1, 1, 16'h003E, 8'h12, rd, lat);
    chk("R8 sp high", spOut, 16'h1234);
    acc(1, 0, 16'h005D, 8'h56, rd, lat);
    chk("R8 low keeps high", spOut, 16'h1256);
    acc(0, 0, 16'h005E, 8'h00, rd, lat);
    chk("R8 high read", rd, 8'h12);
    acc(0, 1, 16'h003D, 8'h00, rd, lat);
    chk("R8 low read", rd, 8'h56);
    acc1(1, 16'h003E, 8'hAB, rd);
    chk("R8 one-byte high ignored", sp1, 0);
    acc1(0, 16'h003E, 8'h00, rd);
    chk("R8 one-byte high read", rd, 0);
    acc1(1, 16'h003D, 8'hC7, rd);
    chk("R8 one-byte low", sp1, 16'h00C7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_regfile();
    t_io_bus();
    t_mem_bus();
    t_port_mode();
    t_core_regs();
    t_stack();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule